// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block takes in one asynchronous serial line and recovers characters from it. A frame holds a low start bit, then 7 or 8 data bits sent least-significant first, then an optional parity bit, then one or two high stop bits. The line is sampled on a 16x oversampling tick. That tick comes from a divider which pulses once every n+1 clocks, where n is a programmable divide value.

When a character is complete, it moves into a single-entry receive buffer and the buffer-full flag rises. On that same clock the parity, framing and overrun outcomes of the character are latched into sticky flags, and a summing flag shows whether any of them is set. A receive interrupt pulses once whenever buffer-full goes from 0 to 1.

A CPU-side agent has two strobes. A read strobe takes the buffer and empties it. A status-write strobe clears the error flags. Dropping the block enable returns the receiver to idle and clears every flag.

Top module: `uart_rx_core`

## Requirements
- R1: The oversampling tick pulses once every div_n+1 clocks. A bit lasts 16 ticks, so frames sent at 16*(div_n+1) clocks per bit are decoded correctly for more than one divide value.
- R2: A falling edge is confirmed as a start bit by a sample taken 8 ticks after the edge. If that sample reads high, the receiver returns to idle. No character is delivered and no flag changes.
- R3: With cfg_7bit=1 the receiver takes 7 data bits, and bit 7 of rx_data reads 0. With cfg_7bit=0 it takes 8 data bits. Data bits arrive least-significant first and are sampled in the middle of each bit.
- R4: With cfg_par_en=1 one parity bit follows the data. cfg_par_odd=0 selects even parity and 1 selects odd parity. A mismatch sets par_err. With cfg_par_en=0 no parity bit is expected.
- R5: A low sample in the middle of the first stop bit sets frm_err. With cfg_two_stop=1 the second stop bit is waited out but not checked.
- R6: At the middle of the first stop bit the character is copied into rx_data. On that same clock buf_full becomes 1 and the error flags are updated.
- R7: If a character completes while buf_full is 1 and no read strobe is present on that clock, ovr_err is set, the new character replaces rx_data, and buf_full stays 1.
- R8: A read strobe clears buf_full and leaves the error flags unchanged.
- R9: A status-write strobe clears ovr_err, par_err, frm_err and sum_err, and leaves buf_full and rx_data unchanged. A character that completes on the same clock still sets its own flags.
- R10: While en is 0, and after reset, buf_full, every error flag and rx_irq are 0.
- R11: rx_irq is a one-clock pulse on the clock where buf_full rises. An overrun, where buf_full stays 1, raises no pulse.
- R12: The error flags are sticky until cleared. sum_err equals the OR of ovr_err, par_err and frm_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; 0 holds idle and clears flags |
| div_n | input | DIV_W | Tick divider value n (tick every n+1 clocks) |
| cfg_7bit | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_par_en | input | 1 | 1 = parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| rxd | input | 1 | Serial input line, idle high |
| rd_buf | input | 1 | Receive buffer read strobe |
| wr_status | input | 1 | Status write strobe (clears errors) |
| rx_data | output | DATA_W | Receive buffer contents |
| buf_full | output | 1 | Receive buffer full |
| ovr_err | output | 1 | Overrun error |
| par_err | output | 1 | Parity error |
| frm_err | output | 1 | Framing error |
| sum_err | output | 1 | Summing error (OR of the three errors) |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench sends a short low glitch on the line. A receiver that skips the mid-start check would deliver a stray 0xFF character. It sends a second character without reading the first. A design that gets this wrong either keeps the stale byte, raises a fresh interrupt, or loses the overrun flag when the buffer is later read. It checks that a status write leaves buf_full alone, which a design that clears every status bit together would fail. The framing case runs with two stop bits, so a receiver that checks or mistimes the second stop bit would raise frm_err on good frames.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP1,
    RX_STOP2
  } rx_state_e;

  localparam int CHAR_W = 8;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              par_bad;
    logic              stop_bad;
  } rx_char_t;

endpackage

// File: rtl/rx_tick_div.sv
module rx_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q >= div_n) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
      tick  <= 1'b0;
    end
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (div_n != '0 && tick) |=> !tick);

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int OS_W   = 4,
  parameter int DATA_W = CHAR_W
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     tick,
  input  logic     rxd,
  input  logic     cfg_7bit,
  input  logic     cfg_par_en,
  input  logic     cfg_par_odd,
  input  logic     cfg_two_stop,
  output logic     char_done,
  output rx_char_t char_out
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [OS_W-1:0] OS_LAST = OS_W'((1 << OS_W) - 1);
  localparam logic [OS_W-1:0] OS_MID  = OS_W'((1 << (OS_W - 1)) - 1);

  rx_state_e         state_q;
  logic [1:0]        sync_q;
  logic              rx_s;
  logic [OS_W-1:0]   os_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last_idx;
  logic [DATA_W-1:0] sh_q;
  logic              acc_q;
  logic              perr_q;
  logic              ferr_q;
  logic              done_q;

  assign rx_s     = sync_q[1];
  assign last_idx = cfg_7bit ? IDX_W'(DATA_W - 2) : IDX_W'(DATA_W - 1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], rxd};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state_q <= RX_IDLE;
      os_q    <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        case (state_q)
          RX_IDLE: begin
            if (!rx_s) begin
              state_q <= RX_START;
              os_q    <= '0;
            end
          end
          RX_START: begin
            if (os_q == OS_MID) begin
              os_q <= '0;
              if (rx_s) begin
                state_q <= RX_IDLE;
              end else begin
                state_q <= RX_DATA;
                idx_q   <= '0;
                sh_q    <= '0;
                acc_q   <= 1'b0;
                perr_q  <= 1'b0;
              end
            end else begin
              os_q <= os_q + OS_W'(1);
            end
          end
          RX_DATA: begin
            if (os_q == OS_LAST) begin
              os_q        <= '0;
              sh_q[idx_q] <= rx_s;
              acc_q       <= acc_q ^ rx_s;
              if (idx_q == last_idx) begin
                state_q <= cfg_par_en ? RX_PAR : RX_STOP1;
              end else begin
                idx_q <= idx_q + IDX_W'(1);
              end
            end else begin
              os_q <= os_q + OS_W'(1);
            end
          end
          RX_PAR: begin
            if (os_q == OS_LAST) begin
              os_q    <= '0;
              perr_q  <= ((acc_q ^ rx_s) != cfg_par_odd);
              state_q <= RX_STOP1;
            end else begin
              os_q <= os_q + OS_W'(1);
            end
          end
          RX_STOP1: begin
            if (os_q == OS_LAST) begin
              os_q    <= '0;
              ferr_q  <= !rx_s;
              done_q  <= 1'b1;
              state_q <= cfg_two_stop ? RX_STOP2 : RX_IDLE;
            end else begin
              os_q <= os_q + OS_W'(1);
            end
          end
          RX_STOP2: begin
            if (os_q == OS_LAST) begin
              os_q    <= '0;
              state_q <= RX_IDLE;
            end else begin
              os_q <= os_q + OS_W'(1);
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign char_done         = done_q;
  assign char_out.data     = sh_q;
  assign char_out.par_bad  = perr_q;
  assign char_out.stop_bad = ferr_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    char_done |=> !char_done);

  // R2
  start_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_START && tick && os_q == OS_MID && rx_s) |=> !char_done);

endmodule

// File: rtl/rx_status_buf.sv
module rx_status_buf
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = CHAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              char_done,
  input  rx_char_t          char_in,
  input  logic              cfg_7bit,
  input  logic              rd_buf,
  input  logic              wr_status,
  output logic [DATA_W-1:0] rx_data,
  output logic              buf_full,
  output logic              ovr_err,
  output logic              par_err,
  output logic              frm_err,
  output logic              sum_err,
  output logic              rx_irq
);

  logic [DATA_W-1:0] data_d;
  logic full_d, ovr_d, par_d, frm_d, sum_d, irq_d;
  logic ovr_b, par_b, frm_b, sum_b, ovr_new;

  always_comb begin
    ovr_b   = wr_status ? 1'b0 : ovr_err;
    par_b   = wr_status ? 1'b0 : par_err;
    frm_b   = wr_status ? 1'b0 : frm_err;
    sum_b   = wr_status ? 1'b0 : sum_err;
    ovr_new = buf_full && !rd_buf;
    data_d  = rx_data;
    full_d  = buf_full && !rd_buf;
    ovr_d   = ovr_b;
    par_d   = par_b;
    frm_d   = frm_b;
    sum_d   = sum_b;
    if (!en) begin
      full_d = 1'b0;
      ovr_d  = 1'b0;
      par_d  = 1'b0;
      frm_d  = 1'b0;
      sum_d  = 1'b0;
    end else if (char_done) begin
      data_d = cfg_7bit ? {1'b0, char_in.data[DATA_W-2:0]} : char_in.data;
      full_d = 1'b1;
      ovr_d  = ovr_b | ovr_new;
      par_d  = par_b | char_in.par_bad;
      frm_d  = frm_b | char_in.stop_bad;
      sum_d  = sum_b | ovr_new | char_in.par_bad | char_in.stop_bad;
    end
    irq_d = full_d && !buf_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      buf_full <= 1'b0;
      ovr_err  <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      sum_err  <= 1'b0;
      rx_irq   <= 1'b0;
    end else begin
      rx_data  <= data_d;
      buf_full <= full_d;
      ovr_err  <= ovr_d;
      par_err  <= par_d;
      frm_err  <= frm_d;
      sum_err  <= sum_d;
      rx_irq   <= irq_d;
    end
  end

  // R3
  seven_bit_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (en && char_done && cfg_7bit) |=> !rx_data[DATA_W-1]);

  // R6
  fill_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    (en && char_done) |=> buf_full);

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (en && char_done && buf_full && !rd_buf) |=> (ovr_err && buf_full));

  // R8
  read_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_buf && !char_done) |=> !buf_full);

  // R9
  status_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (en && wr_status && !char_done && !rd_buf) |=>
      (!ovr_err && !par_err && !frm_err && !sum_err && $stable(buf_full)));

  // R10
  disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!buf_full && !ovr_err && !par_err && !frm_err && !sum_err));

  // R11
  irq_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_full) |-> rx_irq);

  // R11
  irq_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> buf_full);

  // R12
  sum_is_or_chk: assert property (@(posedge clk) disable iff (rst)
    sum_err |-> (ovr_err || par_err || frm_err));

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = CHAR_W,
  parameter int DIV_W  = 8,
  parameter int OS_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIV_W-1:0]  div_n,
  input  logic              cfg_7bit,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              rxd,
  input  logic              rd_buf,
  input  logic              wr_status,
  output logic [DATA_W-1:0] rx_data,
  output logic              buf_full,
  output logic              ovr_err,
  output logic              par_err,
  output logic              frm_err,
  output logic              sum_err,
  output logic              rx_irq
);

  logic     tick;
  logic     char_done;
  rx_char_t char_bus;

  rx_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .div_n (div_n),
    .tick  (tick)
  );

  rx_frame_fsm #(.OS_W(OS_W), .DATA_W(DATA_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .tick         (tick),
    .rxd          (rxd),
    .cfg_7bit     (cfg_7bit),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_odd  (cfg_par_odd),
    .cfg_two_stop (cfg_two_stop),
    .char_done    (char_done),
    .char_out     (char_bus)
  );

  rx_status_buf #(.DATA_W(DATA_W)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .char_done (char_done),
    .char_in   (char_bus),
    .cfg_7bit  (cfg_7bit),
    .rd_buf    (rd_buf),
    .wr_status (wr_status),
    .rx_data   (rx_data),
    .buf_full  (buf_full),
    .ovr_err   (ovr_err),
    .par_err   (par_err),
    .frm_err   (frm_err),
    .sum_err   (sum_err),
    .rx_irq    (rx_irq)
  );

endmodule

// File: tb/uart_rx_core_tb.sv
module uart_rx_core_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [7:0] div_n = 8'd3;
  logic       cfg_7bit = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       rxd = 1'b1;
  logic       rd_buf = 1'b0;
  logic       wr_status = 1'b0;
  logic [7:0] rx_data;
  logic       buf_full, ovr_err, par_err, frm_err, sum_err, rx_irq;

  int  n_checks = 0;
  int  n_fail = 0;
  int  irq_cnt = 0;
  bit  auto_ack = 1'b1;
  bit  finished = 1'b0;

  typedef struct {
    logic [7:0] d;
    logic       p;
    logic       f;
    logic       o;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  uart_rx_core u_dut (
    .clk(clk), .rst(rst), .en(en), .div_n(div_n),
    .cfg_7bit(cfg_7bit), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .rxd(rxd), .rd_buf(rd_buf), .wr_status(wr_status),
    .rx_data(rx_data), .buf_full(buf_full), .ovr_err(ovr_err), .par_err(par_err),
    .frm_err(frm_err), .sum_err(sum_err), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (16 * (int'(div_n) + 1)) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par,
                            input bit bad_stop, input bit push);
    int   nb;
    logic p;
    logic [7:0] dm;
    exp_t e;
    nb = cfg_7bit ? 7 : 8;
    dm = cfg_7bit ? {1'b0, d[6:0]} : d;
    p  = (^dm) ^ cfg_par_odd ^ bad_par;
    if (push) begin
      e.d = dm;
      e.p = bad_par & cfg_par_en;
      e.f = bad_stop;
      e.o = 1'b0;
      exp_q.push_back(e);
    end
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (cfg_par_en) drive_bit(p);
    drive_bit(!bad_stop);
    if (cfg_two_stop) drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd_buf = 1'b1;
    @(negedge clk) rd_buf = 1'b0;
  endtask

  task automatic pulse_wr();
    @(negedge clk) wr_status = 1'b1;
    @(negedge clk) wr_status = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // Monitor: pop an expected item on each interrupt and compare.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && rx_irq) begin
        irq_cnt++;
        if (exp_q.size() == 0) begin
          chk("R11", "unexpected irq", 32'd1, 32'd0);
        end else begin
          e = exp_q.pop_front();
          chk("R6", "rx_data", 32'(rx_data), 32'(e.d));
          chk("R11", "buf_full with irq", 32'(buf_full), 32'd1);
          chk("R4", "par_err", 32'(par_err), 32'(e.p));
          chk("R5", "frm_err", 32'(frm_err), 32'(e.f));
          chk("R7", "ovr_err", 32'(ovr_err), 32'(e.o));
          chk("R12", "sum_err", 32'(sum_err), 32'(e.p | e.f | e.o));
        end
        if (auto_ack) begin
          pulse_rd();
          pulse_wr();
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int irq_before;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10", "reset buf_full", 32'(buf_full), 32'd0);
    chk("R10", "reset errors", 32'({ovr_err, par_err, frm_err, sum_err}), 32'd0);
    chk("R10", "reset irq", 32'(rx_irq), 32'd0);
    en = 1'b1;
    repeat (4) @(negedge clk);

    // R6 R1: 8 data bits, no parity, 1 stop
    send_frame(8'hA5, 1'b0, 1'b0, 1'b1);
    send_frame(8'h3C, 1'b0, 1'b0, 1'b1);

    // R4 even parity good then bad
    cfg_par_en = 1'b1;
    send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
    send_frame(8'h81, 1'b1, 1'b0, 1'b1);
    // R4 odd parity
    cfg_par_odd = 1'b1;
    send_frame(8'h0F, 1'b0, 1'b0, 1'b1);
    send_frame(8'h0E, 1'b1, 1'b0, 1'b1);

    // R3 seven-bit characters, with and without parity
    cfg_7bit = 1'b1;
    send_frame(8'hFF, 1'b0, 1'b0, 1'b1);
    cfg_par_en = 1'b0;
    send_frame(8'hC3, 1'b0, 1'b0, 1'b1);
    cfg_7bit = 1'b0;

    // R5 framing, two stop bits: good frame then bad first stop
    cfg_two_stop = 1'b1;
    send_frame(8'h66, 1'b0, 1'b0, 1'b1);
    send_frame(8'h99, 1'b0, 1'b1, 1'b1);

    // R2 glitch rejection
    irq_before = irq_cnt;
    rxd = 1'b0;
    repeat (20) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * 64) @(negedge clk);
    chk("R2", "glitch irq count", 32'(irq_cnt), 32'(irq_before));
    chk("R2", "glitch buf_full", 32'(buf_full), 32'd0);
    chk("R2", "glitch errors", 32'({ovr_err, par_err, frm_err}), 32'd0);

    // R1 second divide value
    cfg_two_stop = 1'b0;
    div_n = 8'd1;
    repeat (4) @(negedge clk);
    send_frame(8'h96, 1'b0, 1'b0, 1'b1);
    send_frame(8'h01, 1'b0, 1'b0, 1'b1);
    div_n = 8'd3;
    repeat (4) @(negedge clk);

    // R7 overrun
    auto_ack = 1'b0;
    send_frame(8'h11, 1'b0, 1'b0, 1'b1);
    irq_before = irq_cnt;
    send_frame(8'h22, 1'b0, 1'b0, 1'b0);
    chk("R7", "overrun flag", 32'(ovr_err), 32'd1);
    chk("R7", "overrun full", 32'(buf_full), 32'd1);
    chk("R7", "overrun data replaced", 32'(rx_data), 32'h22);
    chk("R12", "overrun sum", 32'(sum_err), 32'd1);
    chk("R11", "no irq on overrun", 32'(irq_cnt), 32'(irq_before));

    // R8 read clears full only
    pulse_rd();
    @(negedge clk);
    chk("R8", "read clears full", 32'(buf_full), 32'd0);
    chk("R8", "read keeps ovr", 32'(ovr_err), 32'd1);

    // R9 status write clears errors
    pulse_wr();
    @(negedge clk);
    chk("R9", "write clears ovr", 32'(ovr_err), 32'd0);
    chk("R9", "write clears sum", 32'(sum_err), 32'd0);

    // R9 status write leaves buf_full and data
    cfg_par_en = 1'b1;
    send_frame(8'h33, 1'b1, 1'b0, 1'b1);
    pulse_wr();
    @(negedge clk);
    chk("R9", "write clears par", 32'(par_err), 32'd0);
    chk("R9", "write keeps full", 32'(buf_full), 32'd1);
    chk("R9", "write keeps data", 32'(rx_data), 32'h33);
    cfg_par_en = 1'b0;

    // R10 disable clears full and errors
    pulse_rd();
    cfg_two_stop = 1'b1;
    send_frame(8'h44, 1'b0, 1'b1, 1'b1);
    chk("R5", "frm before disable", 32'(frm_err), 32'd1);
    @(negedge clk) en = 1'b0;
    @(negedge clk) en = 1'b1;
    @(negedge clk);
    chk("R10", "disable clears full", 32'(buf_full), 32'd0);
    chk("R10", "disable clears errors", 32'({ovr_err, par_err, frm_err, sum_err}), 32'd0);

    // recovery after re-enable
    auto_ack = 1'b1;
    cfg_two_stop = 1'b0;
    repeat (4) @(negedge clk);
    send_frame(8'h55, 1'b0, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    chk("R6", "all expected frames seen", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

endmodule